// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. On a start request it first clears the integrator through an auto-zero switch for a fixed number of cycles. It then connects the unknown signal to the integrator for a run-up window of exactly 2^k clock cycles. After that it connects a reference of the opposite polarity and counts clock cycles until the zero-crossing comparator reports that the integrator has returned through zero. That run-down count is the conversion result. It is proportional to the input and inversely proportional to the reference.

The run-up exponent k is an input. A larger k lengthens the run-up and gives proportionally more counts of resolution, at the cost of a slower conversion. The polarity of the reference is chosen from the comparator at the end of run-up, so bipolar inputs are accepted, and the input sign is reported with the count. If the comparator never trips within twice the run-up length, run-down is cut short and an over-range flag is raised. The integrator, switches and comparator are analog parts outside this block.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held and after its release, the block is idle: busy, done, every switch control, result, sign and over-range are 0.
- R2: A start pulse seen while idle asserts the auto-zero switch for exactly AZ_CYCLES consecutive cycles. Run-up follows immediately after.
- R3: Run-up asserts the input switch for exactly 2^k consecutive cycles. k is `runup_log2` sampled on the accepted start pulse. Values above MAX_LOG2 are clamped to MAX_LOG2.
- R4: If the comparator is high (integrator positive) in the last run-up cycle, run-down drives the negative-reference switch and the reported sign is 0. Otherwise run-down drives the positive-reference switch and the reported sign is 1.
- R5: The result is the number of run-down cycles up to and including the first cycle in which the comparator shows the crossing. With the negative reference the crossing is the comparator low. With the positive reference it is the comparator high.
- R6: If no crossing is seen within 2^(k+1) run-down cycles, run-down ends with over-range = 1 and result = 2^(k+1). A crossing seen in that last allowed cycle is in range (over-range = 0).
- R7: Done is high for exactly one cycle, which follows the last run-down cycle. The start-to-done distance is AZ_CYCLES + 2^k + run-down cycles + 1. Busy is high from auto-zero through run-down. Result, sign and over-range change only when run-down ends, and they hold until the next conversion ends.
- R8: Start pulses and changes of `runup_log2` during a conversion have no effect on that conversion and do not begin another one.
- R9: At most one of the four switch controls is active in any cycle, and none is active while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only while idle |
| runup_log2 | input | LOG_W | Run-up exponent k (run-up = 2^k cycles) |
| cmp_pos | input | 1 | Zero-crossing comparator, high when the integrator output is positive |
| az_sw | output | 1 | Auto-zero switch: integrator held at zero |
| in_sw | output | 1 | Connects the unknown input to the integrator |
| refp_sw | output | 1 | Connects the positive reference (used for negative inputs) |
| refn_sw | output | 1 | Connects the negative reference (used for positive inputs) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a new result is available |
| result | output | RES_W | Run-down cycle count |
| sign | output | 1 | 1 when the input was found not positive |
| overrange | output | 1 | Run-down timed out |

## Verification
On every cycle the assertions check several properties. The switch controls are mutually exclusive, and all are quiet while idle. Done lasts a single cycle. The phase counter stays inside the auto-zero and run-down windows. The latched run-up length and reference polarity do not move mid-conversion. The stored result changes only when run-down ends. Only the bench's scenarios can show that the count matches the integrator model for each input polarity and run-up length. The same holds for the exact full-scale edge between in-range and over-range, the clamping of large exponents, the end-to-end latency, and that a start pulse during a conversion leaves both the result and the idle state afterwards untouched.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_AZERO = 3'd1,
    PH_RUNUP = 3'd2,
    PH_RUNDN = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;

endpackage

// File: rtl/dsc_timer.sv
module dsc_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  // Free-running phase counter, cleared on every phase change
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/dsc_phase_fsm.sv
module dsc_phase_fsm
  import dsc_pkg::*;
#(
  parameter int MAX_LOG2  = 12,
  parameter int AZ_CYCLES = 8,
  parameter int LOG_W     = 4,
  parameter int RES_W     = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LOG_W-1:0] runup_log2,
  input  logic             cmp_pos,
  input  logic [RES_W-1:0] cnt,
  output phase_t           phase,
  output logic             tmr_clr,
  output logic             pol_neg,
  output logic             finish,
  output logic             over
);

  localparam logic [LOG_W-1:0] KMAX   = LOG_W'(MAX_LOG2);
  localparam logic [RES_W-1:0] AZ_END = RES_W'(AZ_CYCLES - 1);

  phase_t           phase_n;
  logic [LOG_W-1:0] k_q;
  logic [LOG_W-1:0] k_in;
  logic [RES_W-1:0] ru_last;
  logic [RES_W-1:0] rd_last;
  logic             crossed;
  logic             az_end;
  logic             ru_end;
  logic             rd_end;

  assign k_in    = (runup_log2 > KMAX) ? KMAX : runup_log2;
  assign ru_last = (RES_W'(1) << k_q) - RES_W'(1);
  assign rd_last = (RES_W'(2) << k_q) - RES_W'(1);

  // Positive reference (pol_neg) drives integrator up: crossing when it goes positive
  assign crossed = pol_neg ? cmp_pos : ~cmp_pos;
  assign az_end  = (cnt == AZ_END);
  assign ru_end  = (cnt == ru_last);
  assign rd_end  = (cnt == rd_last);

  assign finish  = (phase == PH_RUNDN) && (crossed || rd_end);
  assign over    = ~crossed;

  always_comb begin
    phase_n = phase;
    tmr_clr = 1'b0;
    case (phase)
      PH_IDLE: begin
        tmr_clr = 1'b1;
        if (start) phase_n = PH_AZERO;
      end
      PH_AZERO: begin
        if (az_end) begin
          phase_n = PH_RUNUP;
          tmr_clr = 1'b1;
        end
      end
      PH_RUNUP: begin
        if (ru_end) begin
          phase_n = PH_RUNDN;
          tmr_clr = 1'b1;
        end
      end
      PH_RUNDN: begin
        if (crossed || rd_end) begin
          phase_n = PH_DONE;
          tmr_clr = 1'b1;
        end
      end
      PH_DONE: begin
        phase_n = PH_IDLE;
        tmr_clr = 1'b1;
      end
      default: begin
        phase_n = PH_IDLE;
        tmr_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      k_q     <= '0;
      pol_neg <= 1'b0;
    end else begin
      phase <= phase_n;
      if (phase == PH_IDLE && start) k_q <= k_in;
      if (phase == PH_RUNUP && ru_end) pol_neg <= ~cmp_pos;
    end
  end

  AST_AZ_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_AZERO) |-> (cnt <= AZ_END)); // R2

  AST_RD_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUNDN) |-> (cnt <= rd_last)); // R6

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(k_q)); // R8

  AST_POL_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUNDN) |=> $stable(pol_neg)); // R4

endmodule

// File: rtl/dsc_capture.sv
module dsc_capture #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish,
  input  logic             over,
  input  logic             pol_neg,
  input  logic [RES_W-1:0] cnt,
  output logic [RES_W-1:0] result_q,
  output logic             sign_q,
  output logic             ovr_q
);

  // Count includes the run-down cycle in which the crossing is seen
  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      sign_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else if (finish) begin
      result_q <= cnt + RES_W'(1);
      sign_q   <= pol_neg;
      ovr_q    <= over;
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(result_q) && $stable(sign_q) && $stable(ovr_q)); // R7

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int MAX_LOG2  = 12,
  parameter int AZ_CYCLES = 8,
  parameter int LOG_W     = $clog2(MAX_LOG2 + 1),
  parameter int RES_W     = MAX_LOG2 + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LOG_W-1:0] runup_log2,
  input  logic             cmp_pos,
  output logic             az_sw,
  output logic             in_sw,
  output logic             refp_sw,
  output logic             refn_sw,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             sign,
  output logic             overrange
);

  phase_t           phase;
  logic             tmr_clr;
  logic             pol_neg;
  logic             finish;
  logic             over;
  logic [RES_W-1:0] cnt;

  dsc_timer #(.W(RES_W)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .cnt (cnt)
  );

  dsc_phase_fsm #(
    .MAX_LOG2  (MAX_LOG2),
    .AZ_CYCLES (AZ_CYCLES),
    .LOG_W     (LOG_W),
    .RES_W     (RES_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .runup_log2 (runup_log2),
    .cmp_pos    (cmp_pos),
    .cnt        (cnt),
    .phase      (phase),
    .tmr_clr    (tmr_clr),
    .pol_neg    (pol_neg),
    .finish     (finish),
    .over       (over)
  );

  dsc_capture #(.RES_W(RES_W)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .finish   (finish),
    .over     (over),
    .pol_neg  (pol_neg),
    .cnt      (cnt),
    .result_q (result),
    .sign_q   (sign),
    .ovr_q    (overrange)
  );

  // Switch controls decode straight from the phase and polarity flops
  assign az_sw   = (phase == PH_AZERO);
  assign in_sw   = (phase == PH_RUNUP);
  assign refp_sw = (phase == PH_RUNDN) &&  pol_neg;
  assign refn_sw = (phase == PH_RUNDN) && !pol_neg;
  assign busy    = (phase == PH_AZERO) || (phase == PH_RUNUP) || (phase == PH_RUNDN);
  assign done    = (phase == PH_DONE);

  AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({az_sw, in_sw, refp_sw, refn_sw})); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(az_sw || in_sw || refp_sw || refn_sw)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(refp_sw || refn_sw)); // R7

endmodule

// File: tb/test_dual_slope_seq.sv
module test_dual_slope_seq;

  localparam int MAX_LOG2 = 12;
  localparam int AZ       = 8;
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
  localparam int RES_W    = MAX_LOG2 + 2;
  localparam int REFV     = 100;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [LOG_W-1:0] log2_in = '0;
  logic             cmp = 1'b0;
  logic             az_sw, in_sw, refp_sw, refn_sw, busy, done, sign, overrange;
  logic [RES_W-1:0] result;

  always #4 clk = ~clk;

  dual_slope_seq #(.MAX_LOG2(MAX_LOG2), .AZ_CYCLES(AZ)) i_dual_slope_seq (
    .clk(clk), .rst(rst), .start(start), .runup_log2(log2_in), .cmp_pos(cmp),
    .az_sw(az_sw), .in_sw(in_sw), .refp_sw(refp_sw), .refn_sw(refn_sw),
    .busy(busy), .done(done), .result(result), .sign(sign), .overrange(overrange)
  );

  typedef struct {
    int res; int sgn; int ovr; int tdone; int naz; int nin;
  } exp_t;

  exp_t q[$];
  int   vin = 0, integ = 0, ncnt = 0, naz = 0, nin = 0;
  int   vectors = 0, errors = 0;
  bit   finished = 1'b0;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Ideal integrator and scoreboard monitor, both away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      integ = 0;
      cmp   = 1'b0;
    end else begin
      ncnt++;
      if (az_sw)        integ = 0;
      else if (in_sw)   integ += vin;
      else if (refp_sw) integ += REFV;
      else if (refn_sw) integ -= REFV;
      cmp = (integ > 0);
      if (az_sw) naz++;
      if (in_sw) nin++;
      if (done) begin
        if (q.size() == 0) begin
          check("R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R5 result",        int'(result),    e.res);
          check("R4 sign",          int'(sign),      e.sgn);
          check("R6 overrange",     int'(overrange), e.ovr);
          check("R7 latency",       ncnt,            e.tdone);
          check("R2 autozero len",  naz,             e.naz);
          check("R3 runup len",     nin,             e.nin);
        end
        naz = 0;
        nin = 0;
      end
    end
  end

  task automatic run_conv(int k, int v, bit poke);
    exp_t e;
    int   n, ii, m;
    @(negedge clk); #1;
    n  = 1 << ((k > MAX_LOG2) ? MAX_LOG2 : k);
    ii = n * v;
    if (ii > 0) begin
      e.sgn = 0;
      m = (ii + REFV - 1) / REFV;
    end else begin
      e.sgn = 1;
      m = (-ii) / REFV + 1;
    end
    e.ovr = 0;
    if (m > 2 * n) begin
      e.ovr = 1;
      m = 2 * n;
    end
    e.res   = m;
    e.naz   = AZ;
    e.nin   = n;
    e.tdone = ncnt + AZ + n + m + 1;
    q.push_back(e);
    vin     = v;
    log2_in = LOG_W'(k);
    start   = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R8: start and exponent change mid-conversion must be ignored
      repeat (3) @(negedge clk);
      #1;
      start   = 1'b1;
      log2_in = LOG_W'(9);
      repeat (2) @(negedge clk);
      #1;
      start   = 1'b0;
    end
    do @(negedge clk); while (!done);
    if (poke) begin
      repeat (6) @(negedge clk);
      check("R8 busy after ignored start", int'(busy), 0);
      check("R8 no extra autozero",        int'(az_sw), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy",      int'(busy), 0);
    check("R1 done",      int'(done), 0);
    check("R1 switches",  int'({az_sw, in_sw, refp_sw, refn_sw}), 0);
    check("R1 result",    int'(result), 0);
    check("R1 sign/ovr",  int'({sign, overrange}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 idle after release", int'({busy, done, az_sw, in_sw, refp_sw, refn_sw}), 0);

    run_conv(3, 50, 1'b0);    // R5 positive input
    run_conv(4, -37, 1'b0);   // R4 negative input, positive reference
    run_conv(2, 0, 1'b0);     // R4 zero input counts as not positive
    run_conv(0, 150, 1'b0);   // R6 crossing in the last allowed cycle
    run_conv(5, 200, 1'b0);   // R6 exact full scale stays in range
    run_conv(5, -200, 1'b0);  // R6 negative full scale times out
    run_conv(5, 250, 1'b0);   // R6 over-range positive
    run_conv(15, 7, 1'b0);    // R3 exponent clamp
    run_conv(6, -1, 1'b0);    // R5 small negative
    run_conv(6, 1, 1'b0);     // R5 small positive
    run_conv(3, 30, 1'b1);    // R8 ignored start during conversion
    run_conv(7, -123, 1'b0);  // R5 mixed
    repeat (4) @(negedge clk);
    check("R7 queue drained", q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule